// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is the arithmetic and logic stage of a small accumulator machine. It is purely combinational. Each cycle it takes a 3-bit operation code, the two bytes of the accumulator (low and high) and an operand byte that was just read from memory into the data register. From these it computes the values the accumulator should take next. The surrounding control logic loads the low byte from `acc_lo_nxt` on every execute step. It loads the high byte from `acc_hi_nxt` only while `acc_hi_we` is asserted.

There are eight operations: add, multiply, unsigned integer divide, XOR, NAND, even-parity insertion, clear and halt. Most operations read only the low accumulator byte and write back only the low byte. Multiply is the one exception: it writes a double-width product across both bytes. The parity operation does not use the operand. It replaces the top bit of the low byte so that the whole byte has even parity. Halt leaves the accumulator as it is.

Top module: `acc_alu_core`

## Requirements
- R1: With op_code 000 (halt), acc_lo_nxt equals acc_lo, acc_hi_nxt equals acc_hi, and acc_hi_we is 0.
- R2: With op_code 001 (add), acc_lo_nxt is (acc_lo + operand) modulo 2^DATA_W; the carry out is dropped.
- R3: With op_code 010 (multiply), {acc_hi_nxt, acc_lo_nxt} is the full unsigned product acc_lo * operand, and acc_hi_we is 1.
- R4: With op_code 011 (divide) and a nonzero operand, acc_lo_nxt is the unsigned quotient floor(acc_lo / operand).
- R5: With op_code 011 and operand 0, acc_lo_nxt is all ones (8'hFF at the default width).
- R6: With op_code 100 (xor), acc_lo_nxt is acc_lo XOR operand.
- R7: With op_code 101 (parity), bits DATA_W-2..0 of acc_lo_nxt equal those of acc_lo, and the top bit is the XOR of those lower bits, so acc_lo_nxt has an even number of ones; the operand has no effect.
- R8: With op_code 110 (nand), acc_lo_nxt is the bitwise NOT of (acc_lo AND operand).
- R9: With op_code 111 (clear), acc_lo_nxt is 0.
- R10: For every op_code other than 010, acc_hi_nxt equals acc_hi and acc_hi_we is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation selector |
| acc_lo | input | DATA_W | Current low accumulator byte |
| acc_hi | input | DATA_W | Current high accumulator byte |
| operand | input | DATA_W | Operand held in the data register |
| acc_lo_nxt | output | DATA_W | Next value of the low accumulator byte |
| acc_hi_nxt | output | DATA_W | Next value of the high accumulator byte |
| acc_hi_we | output | 1 | High-byte load enable (multiply only) |

## Verification
The bench builds the block at its default DATA_W of 8. At that width the whole divide space can be swept: every dividend against every divisor, zero included. That sweep reaches the all-ones result for divide by zero, quotients of 1 and 0 at the edges, and every remainder boundary. A dense multiply grid is also run, and it reaches the 16'hFE01 extreme. Every parity input is swept, and directed cases exercise add wrap-around and carry loss.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation encoding and width for the accumulator ALU.
// Assumes a fixed 3-bit operation field; data width is a parameter elsewhere.
package acc_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HOLD = 3'b000,
        OP_ADD  = 3'b001,
        OP_MUL  = 3'b010,
        OP_DIV  = 3'b011,
        OP_XOR  = 3'b100,
        OP_PAR  = 3'b101,
        OP_NAND = 3'b110,
        OP_CLR  = 3'b111
    } acc_op_e;

endpackage

// File: rtl/acc_bitwise_unit.sv
// Module: single-width results for add, xor, nand and parity insertion.
// Assumes DATA_W >= 2; the add result is truncated to DATA_W bits.
module acc_bitwise_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] nand_o,
    output logic [DATA_W-1:0] par_o
);

    localparam int LOW_BITS = DATA_W - 1;

    logic [DATA_W:0]   sum_full;
    logic              par_bit;

    // Full-width sum; the top carry bit is dropped on purpose.
    assign sum_full = {1'b0, lhs} + {1'b0, rhs};
    assign sum_o    = sum_full[DATA_W-1:0];

    // Bitwise logic results.
    assign xor_o  = lhs ^ rhs;
    assign nand_o = ~(lhs & rhs);

    // Even-parity bit over the low bits, placed in the top position.
    always_comb begin
        par_bit = 1'b0;
        for (int i = 0; i < LOW_BITS; i++) begin
            par_bit = par_bit ^ lhs[i];
        end
    end

    assign par_o = {par_bit, lhs[LOW_BITS-1:0]};

endmodule

// File: rtl/acc_multiplier.sv
// Module: unsigned shift-and-add multiplier producing a double-width product.
// Assumes unsigned operands; purely combinational.
module acc_multiplier #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   mcand,
    input  logic [DATA_W-1:0]   mplier,
    output logic [2*DATA_W-1:0] product
);

    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0][PROD_W-1:0] partial;

    // One shifted partial product per multiplier bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_partial
        assign partial[g] = mplier[g] ? (PROD_W'(mcand) << g) : '0;
    end

    // Sum all partial products.
    always_comb begin
        product = '0;
        for (int i = 0; i < DATA_W; i++) begin
            product = product + partial[i];
        end
    end

endmodule

// File: rtl/acc_divider.sv
// Module: unsigned restoring divider, one unrolled stage per quotient bit.
// Assumes unsigned operands; a zero divisor yields an all-ones quotient.
module acc_divider #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] quotient
);

    localparam int REM_W = DATA_W + 1;

    logic [DATA_W:0][REM_W-1:0] rem_chain;
    logic [DATA_W-1:0]          q_bits;
    logic                       div_zero;

    assign rem_chain[0] = '0;

    // Each stage brings down one dividend bit (MSB first) and trial-subtracts.
    for (genvar s = 0; s < DATA_W; s++) begin : g_stage
        localparam int BIT_IDX = DATA_W - 1 - s;
        logic [REM_W-1:0] shifted;
        logic [REM_W-1:0] trial;
        assign shifted = {rem_chain[s][DATA_W-1:0], dividend[BIT_IDX]};
        assign trial   = shifted - {1'b0, divisor};
        assign q_bits[BIT_IDX] = ~trial[REM_W-1];
        assign rem_chain[s+1]  = q_bits[BIT_IDX] ? trial : shifted;
    end

    // Zero divisor forced to the saturated value explicitly.
    assign div_zero = (divisor == '0);
    assign quotient = div_zero ? '1 : q_bits;

endmodule

// File: rtl/acc_alu_core.sv
// Module: top of the accumulator ALU; selects the result for the opcode.
// Assumes the caller loads the low byte every execute step and the high
// byte only when acc_hi_we is set. No state, no clock.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] acc_lo,
    input  logic [DATA_W-1:0] acc_hi,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_lo_nxt,
    output logic [DATA_W-1:0] acc_hi_nxt,
    output logic              acc_hi_we
);

    localparam int PROD_W = 2 * DATA_W;

    acc_op_e           op;
    logic [DATA_W-1:0] sum_r, xor_r, nand_r, par_r, quot_r;
    logic [PROD_W-1:0] prod_r;

    assign op = acc_op_e'(op_code);

    acc_bitwise_unit #(.DATA_W(DATA_W)) u_bitwise (
        .lhs    (acc_lo),
        .rhs    (operand),
        .sum_o  (sum_r),
        .xor_o  (xor_r),
        .nand_o (nand_r),
        .par_o  (par_r)
    );

    acc_multiplier #(.DATA_W(DATA_W)) u_mult (
        .mcand   (acc_lo),
        .mplier  (operand),
        .product (prod_r)
    );

    acc_divider #(.DATA_W(DATA_W)) u_div (
        .dividend (acc_lo),
        .divisor  (operand),
        .quotient (quot_r)
    );

    // Result selection by opcode; high byte moves only on multiply.
    always_comb begin
        acc_lo_nxt = acc_lo;
        acc_hi_nxt = acc_hi;
        acc_hi_we  = 1'b0;
        case (op)
            OP_HOLD: acc_lo_nxt = acc_lo;
            OP_ADD:  acc_lo_nxt = sum_r;
            OP_MUL: begin
                acc_lo_nxt = prod_r[DATA_W-1:0];
                acc_hi_nxt = prod_r[PROD_W-1:DATA_W];
                acc_hi_we  = 1'b1;
            end
            OP_DIV:  acc_lo_nxt = quot_r;
            OP_XOR:  acc_lo_nxt = xor_r;
            OP_PAR:  acc_lo_nxt = par_r;
            OP_NAND: acc_lo_nxt = nand_r;
            OP_CLR:  acc_lo_nxt = '0;
            default: acc_lo_nxt = acc_lo;
        endcase
    end

endmodule

// File: rtl/acc_alu_checker.sv
// Module: property checker for acc_alu_core, bound to every instance.
// Assumes combinational settling before evaluation; immediate checks only.
module acc_alu_checker #(
    parameter int DATA_W = 8
) (
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] acc_lo,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc_lo_nxt,
    input logic [DATA_W-1:0] acc_hi_nxt,
    input logic              acc_hi_we
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] back_prod;
    logic [PROD_W-1:0] wide_lo;
    logic [PROD_W-1:0] wide_opd;
    logic [DATA_W-1:0] add_delta;

    assign back_prod = PROD_W'(acc_lo_nxt) * PROD_W'(operand);
    assign wide_lo   = PROD_W'(acc_lo);
    assign wide_opd  = PROD_W'(operand);
    assign add_delta = acc_lo_nxt - acc_lo;

    // Per-opcode result properties.
    always_comb begin
        if (op_code == 3'b000)
            AST_HOLD_ALL: assert (acc_lo_nxt == acc_lo && acc_hi_nxt == acc_hi && !acc_hi_we) else $error("hold"); // R1
        if (op_code == 3'b001)
            AST_ADD_WRAP: assert (add_delta == operand) else $error("add"); // R2
        if (op_code == 3'b010 && operand == DATA_W'(1))
            AST_MUL_IDENTITY: assert (acc_hi_nxt == '0 && acc_lo_nxt == acc_lo && acc_hi_we) else $error("mul"); // R3
        if (op_code == 3'b011 && operand != '0)
            AST_DIV_BOUNDS: assert (back_prod <= wide_lo && (wide_lo - back_prod) < wide_opd) else $error("div"); // R4
        if (op_code == 3'b011 && operand == '0)
            AST_DIV_ZERO_SAT: assert (&acc_lo_nxt) else $error("div0"); // R5
        if (op_code == 3'b100)
            AST_XOR_UNDO: assert ((acc_lo_nxt ^ operand) == acc_lo) else $error("xor"); // R6
        if (op_code == 3'b101)
            AST_PARITY_EVEN: assert (!(^acc_lo_nxt) && acc_lo_nxt[DATA_W-2:0] == acc_lo[DATA_W-2:0]) else $error("par"); // R7
        if (op_code == 3'b111)
            AST_CLEAR_LOW: assert (acc_lo_nxt == '0) else $error("clr"); // R9
        if (op_code != 3'b010)
            AST_HIGH_KEEP: assert (acc_hi_nxt == acc_hi && !acc_hi_we) else $error("hi"); // R10
    end

endmodule

bind acc_alu_core acc_alu_checker #(.DATA_W(DATA_W)) u_acc_alu_checker (
    .op_code    (op_code),
    .acc_lo     (acc_lo),
    .acc_hi     (acc_hi),
    .operand    (operand),
    .acc_lo_nxt (acc_lo_nxt),
    .acc_hi_nxt (acc_hi_nxt),
    .acc_hi_we  (acc_hi_we)
);

// File: tb/test_acc_alu_core.sv
// Bench: scoreboard for acc_alu_core. A driver task applies a stimulus and
// queues the independently modelled result; a monitor pops and compares.
module test_acc_alu_core;

    localparam int DATA_W     = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic              we;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_code = 3'b000;
    logic [DATA_W-1:0] acc_lo = '0;
    logic [DATA_W-1:0] acc_hi = '0;
    logic [DATA_W-1:0] operand = '0;
    logic [DATA_W-1:0] acc_lo_nxt;
    logic [DATA_W-1:0] acc_hi_nxt;
    logic              acc_hi_we;

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    acc_alu_core #(.DATA_W(DATA_W)) i_acc_alu_core (
        .op_code    (op_code),
        .acc_lo     (acc_lo),
        .acc_hi     (acc_hi),
        .operand    (operand),
        .acc_lo_nxt (acc_lo_nxt),
        .acc_hi_nxt (acc_hi_nxt),
        .acc_hi_we  (acc_hi_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [2:0] op, input int lo, input int hi, input int d, input string tag);
        exp_t e;
        int   p;
        int   r;
        e.lo = DATA_W'(lo); e.hi = DATA_W'(hi); e.we = 1'b0; e.tag = tag;
        case (op)
            3'b001: e.lo = DATA_W'((lo + d) % 256);
            3'b010: begin p = lo * d; e.lo = DATA_W'(p % 256); e.hi = DATA_W'(p / 256); e.we = 1'b1; end
            3'b011: e.lo = (d == 0) ? 8'hFF : DATA_W'(lo / d);
            3'b100: e.lo = DATA_W'(lo ^ d);
            3'b101: begin
                r = 0;
                for (int i = 0; i < 7; i++) r = r ^ ((lo >> i) & 1);
                e.lo = DATA_W'((lo & 8'h7F) | (r << 7));
            end
            3'b110: e.lo = DATA_W'(~(lo & d) & 8'hFF);
            3'b111: e.lo = '0;
            default: ;
        endcase
        return e;
    endfunction

    // Driver: apply one stimulus after a rising edge and queue its result.
    task automatic drive(input logic [2:0] op, input int lo, input int hi, input int d, input string tag);
        @(posedge clk);
        op_code = op;
        acc_lo  = DATA_W'(lo);
        acc_hi  = DATA_W'(hi);
        operand = DATA_W'(d);
        sb_q.push_back(model(op, lo, hi, d, tag));
    endtask

    // Monitor: compare settled outputs at the falling edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (acc_lo_nxt !== e.lo || acc_hi_nxt !== e.hi || acc_hi_we !== e.we) begin
                    errors++;
                    $display("FAIL %s op=%b lo=%h hi=%h opd=%h: got lo=%h hi=%h we=%b exp lo=%h hi=%h we=%b",
                             e.tag, op_code, acc_lo, acc_hi, operand,
                             acc_lo_nxt, acc_hi_nxt, acc_hi_we, e.lo, e.hi, e.we);
                end
            end
        end
    end

    // Watchdog: an unfinished run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: halt with all-zero inputs (R1).
        drive(3'b000, 0, 0, 0, "R1 reset");
        drive(3'b000, 8'hA5, 8'h3C, 8'hFF, "R1 halt");
        // R2 add, with and without carry loss.
        drive(3'b001, 8'h12, 8'h77, 8'h34, "R2 add");
        drive(3'b001, 8'hFF, 8'h77, 8'h01, "R2 add wrap");
        drive(3'b001, 8'hF0, 8'h00, 8'h20, "R2 add carry");
        // R3 multiply extremes and R10 contrast.
        drive(3'b010, 8'hFF, 8'h55, 8'hFF, "R3 mul max");
        drive(3'b010, 8'h00, 8'h55, 8'h9A, "R3 mul zero");
        drive(3'b010, 8'h10, 8'h55, 8'h10, "R3 mul");
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 3)
                drive(3'b010, a, 8'hC3, b, "R3 mul grid");
        // R4 and R5 divide, exhaustive.
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                drive(3'b011, a, 8'h5A, b, (b == 0) ? "R5 div zero" : "R4 div");
        // R6 xor and R8 nand.
        drive(3'b100, 8'hF0, 8'h11, 8'h3C, "R6 xor");
        drive(3'b100, 8'hAA, 8'h11, 8'hAA, "R6 xor self");
        drive(3'b110, 8'hF0, 8'h22, 8'h3C, "R8 nand");
        drive(3'b110, 8'hFF, 8'h22, 8'hFF, "R8 nand ones");
        // R7 parity, every input value, operand varied to show no effect.
        for (int a = 0; a < 256; a++)
            drive(3'b101, a, 8'h66, 255 - a, "R7 parity");
        // R9 clear.
        drive(3'b111, 8'hDE, 8'hAD, 8'hBE, "R9 clear");
        // R10: high byte untouched on every non-multiply opcode.
        for (int o = 0; o < 8; o++)
            if (o != 2) drive(3'(o), 8'h81, 8'hE7, 8'h07, "R10 hi keep");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule